// File: doc/BRIEF.md
# Stereo Digital Volume with Ramping

This block scales a stereo stream of 24-bit two's complement samples by a per-channel attenuation, and it mutes either channel on request. It advances once per frame strobe. On that strobe it takes one sample per channel, updates each channel's level, and registers the scaled sample. A 2-bit transition mode sets how a new level or a mute is reached. The change can take effect at once, at the next zero crossing of that channel, as a ramp of one eighth-decibel step per frame, or as a ramp whose steps each wait for a zero crossing. A step that waits for a zero crossing is forced once a bounded timeout has passed.

Each channel can mute itself after a long run of silent input. A mute indicator output tells an external analog mute circuit when both channels are silenced. A link flag lets the channel A controls set both channels.

Top module: `stereo_vol_ramp`

## Requirements
- R1: After reset, both sample outputs and the mute indicator are 0 until the first frame strobe.
- R2: The level of a channel is held in eighth-dB units as L = code*8. The applied gain is g = round(65536 * 10^(-(L mod 48)/160)) shifted right by floor(L/48). The output is (x*g + 32768) >>> 16, so code 0 passes the sample unchanged and code 6 halves it.
- R3: An attenuation code of 95 or more, or an asserted mute bit, gives a target level of 760, at which the gain is 0 and the output is 0.
- R4: Mode 00 applies the target level to the sample taken in the same frame.
- R5: Mode 01 keeps the old level until the channel sees a zero crossing: a sample equal to 0, or a sample whose sign differs from that channel's previous sample. The new level applies to that crossing sample. Each channel's crossing is judged on its own.
- R6: In modes 01 and 11, a change that sees no zero crossing is forced between 512 and 1024 frames after it was requested.
- R7: Mode 10 moves the level one eighth-dB step toward the target on every frame.
- R8: Mode 11 moves the level one eighth-dB step toward the target only on frames with a zero crossing.
- R9: A mute request follows the transition mode, so in mode 10 the output fades to 0 step by step.
- R10: When the link flag is 1, the channel A code and mute bit set both channels, and the channel B code and mute bit have no effect.
- R11: When auto-mute is enabled, a channel outputs 0 from the 8192nd consecutive silent sample onward, where a silent sample is all 0 or all 1. The first non-silent sample passes through in its own frame. With auto-mute disabled, silent input is never forced to 0.
- R12: The mute indicator is 1 after a frame in which both channels request mute (R3, after linking), or in which both channels are auto-muted.
- R13: All outputs change only at the clock edge that samples the frame strobe, and they hold between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | One-cycle strobe, one per stereo frame |
| smp_a_i | input | 24 | Channel A input sample |
| smp_b_i | input | 24 | Channel B input sample |
| atten_a_i | input | 7 | Channel A attenuation, 1 dB per LSB |
| atten_b_i | input | 7 | Channel B attenuation, 1 dB per LSB |
| mute_a_i | input | 1 | Channel A mute request |
| mute_b_i | input | 1 | Channel B mute request |
| link_i | input | 1 | Channel A controls set both channels |
| tmode_i | input | 2 | Transition mode: 00 now, 01 zero crossing, 10 ramp, 11 ramp on crossings |
| am_en_i | input | 1 | Auto-mute enable |
| out_a_o | output | 24 | Channel A scaled sample |
| out_b_o | output | 24 | Channel B scaled sample |
| mute_ind_o | output | 1 | Mute indicator |

## Verification
Every scaled sample and the mute indicator are due at the rising edge that samples the frame strobe. No further register lies on the path, so the result for frame n belongs to frame n alone. The driver holds the strobe high for exactly one cycle, starting at a falling edge. It pushes the expected pair for that frame, and the monitor pops and compares it at the next falling edge, half a cycle after the result settles. The zero-crossing timeout depends on a free-running frame count that the bench does not copy, so that case is not queued: the bench counts frames from the request until the output changes and checks the count against the allowed window.

// File: rtl/vol_pkg.sv
package vol_pkg;
  localparam int SMP_W     = 24;
  localparam int CODE_W    = 7;
  localparam int LVL_W     = 10;
  localparam int EIGHTHS   = 8;            // level units per dB
  localparam int MUTE_CODE = 95;           // codes at or above this mute
  localparam int MUTE_LVL  = MUTE_CODE * EIGHTHS;
  localparam int OCT_STEPS = 48;           // 6 dB per halving of gain
  localparam int GAIN_FRAC = 16;
  localparam int GAIN_W    = GAIN_FRAC + 1;

  typedef enum logic [1:0] {
    TM_NOW     = 2'b00,
    TM_ZC      = 2'b01,
    TM_RAMP    = 2'b10,
    TM_RAMP_ZC = 2'b11
  } tmode_e;
endpackage

// File: rtl/vol_gain.sv
module vol_gain
  import vol_pkg::*;
(
  input  logic [LVL_W-1:0]  lvl_i,
  output logic [GAIN_W-1:0] gain_o
);
  localparam int FRAC_W = $clog2(OCT_STEPS);
  localparam int SHF_W  = $clog2(MUTE_LVL / OCT_STEPS + 1);

  logic [GAIN_W-1:0] tab [OCT_STEPS];
  logic [FRAC_W-1:0] frac;
  logic [SHF_W-1:0]  shf;

  // one octave of eighth-dB gains, computed at elaboration
  for (genvar i = 0; i < OCT_STEPS; i++) begin : g_tab
    assign tab[i] = GAIN_W'($rtoi(65536.0 * (10.0 ** (-real'(i) / 160.0)) + 0.5));
  end

  assign frac = FRAC_W'(lvl_i % LVL_W'(OCT_STEPS));
  assign shf  = SHF_W'(lvl_i / LVL_W'(OCT_STEPS));

  always_comb begin
    if (lvl_i >= LVL_W'(MUTE_LVL)) gain_o = '0;
    else                           gain_o = tab[frac] >> shf;
  end
endmodule

// File: rtl/vol_chan.sv
module vol_chan
  import vol_pkg::*;
#(
  parameter int SIL_RUN = 8192,
  parameter int SIL_W   = $clog2(SIL_RUN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic              tick_i,
  input  logic [SMP_W-1:0]  smp_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              mute_i,
  input  logic [1:0]        mode_i,
  input  logic              am_en_i,
  output logic [SMP_W-1:0]  out_o,
  output logic              am_o,
  output logic              req_mute_o
);
  localparam int PROD_W = SMP_W + GAIN_W + 1;
  localparam logic signed [PROD_W-1:0] RND = PROD_W'(1) <<< (GAIN_FRAC - 1);

  tmode_e                    mode;
  logic [LVL_W-1:0]          lvl_q, lvl_nxt, tgt, step;
  logic                      prev_neg_q, seen_q, am_q;
  logic [SIL_W-1:0]          sil_cnt_q;
  logic                      zc, to, go, silent, am_nxt;
  logic [GAIN_W-1:0]         gain;
  logic signed [PROD_W-1:0]  prod, rsum;
  logic [SMP_W-1:0]          out_q;

  assign mode       = tmode_e'(mode_i);
  assign req_mute_o = mute_i || (code_i >= CODE_W'(MUTE_CODE));
  assign tgt        = req_mute_o ? LVL_W'(MUTE_LVL) : LVL_W'({code_i, 3'b000});

  assign zc = (smp_i == '0) || (smp_i[SMP_W-1] != prev_neg_q);
  assign to = seen_q && tick_i;
  assign go = zc || to;

  always_comb begin
    if (lvl_q < tgt)      step = lvl_q + 1'b1;
    else if (lvl_q > tgt) step = lvl_q - 1'b1;
    else                  step = lvl_q;
  end

  always_comb begin
    unique case (mode)
      TM_NOW:     lvl_nxt = tgt;
      TM_ZC:      lvl_nxt = go ? tgt : lvl_q;
      TM_RAMP:    lvl_nxt = step;
      TM_RAMP_ZC: lvl_nxt = go ? step : lvl_q;
      default:    lvl_nxt = lvl_q;
    endcase
  end

  vol_gain u_gain (
    .lvl_i  (lvl_nxt),
    .gain_o (gain)
  );

  assign prod = $signed(smp_i) * $signed({1'b0, gain});
  assign rsum = (prod + RND) >>> GAIN_FRAC;

  assign silent = (smp_i == '0) || (smp_i == '1);
  assign am_nxt = am_en_i && silent && (sil_cnt_q >= SIL_W'(SIL_RUN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q      <= '0;
      prev_neg_q <= 1'b0;
      seen_q     <= 1'b0;
      sil_cnt_q  <= '0;
      am_q       <= 1'b0;
      out_q      <= '0;
    end else if (frame_i) begin
      lvl_q      <= lvl_nxt;
      prev_neg_q <= smp_i[SMP_W-1];
      // timeout arms on the first tick of a wait, fires on the second
      if (lvl_q == tgt || lvl_nxt != lvl_q) seen_q <= 1'b0;
      else if (tick_i)                      seen_q <= 1'b1;
      if (!(am_en_i && silent))             sil_cnt_q <= '0;
      else if (sil_cnt_q < SIL_W'(SIL_RUN)) sil_cnt_q <= sil_cnt_q + 1'b1;
      am_q  <= am_nxt;
      out_q <= am_nxt ? '0 : SMP_W'(rsum);
    end
  end

  assign out_o = out_q;
  assign am_o  = am_q;

  a_r3_lvl_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_q <= LVL_W'(MUTE_LVL));

  a_r4_now_lvl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && mode == TM_NOW) |=> lvl_q == $past(tgt));

  a_r5_zc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && mode == TM_ZC && !zc && !to) |=> $stable(lvl_q));

  a_r7_one_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && mode == TM_RAMP) |=>
      (lvl_q == $past(lvl_q) || lvl_q == $past(lvl_q) + 1'b1 || lvl_q + 1'b1 == $past(lvl_q)));

  a_r11_am_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(am_q) |-> $past(sil_cnt_q) >= SIL_W'(SIL_RUN - 1));

  a_r13_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable(out_q));
endmodule

// File: rtl/stereo_vol_ramp.sv
module stereo_vol_ramp
  import vol_pkg::*;
#(
  parameter int TO_LOG2 = 9,
  parameter int SIL_RUN = 8192
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        frame_i,
  input  logic [23:0] smp_a_i,
  input  logic [23:0] smp_b_i,
  input  logic [6:0]  atten_a_i,
  input  logic [6:0]  atten_b_i,
  input  logic        mute_a_i,
  input  logic        mute_b_i,
  input  logic        link_i,
  input  logic [1:0]  tmode_i,
  input  logic        am_en_i,
  output logic [23:0] out_a_o,
  output logic [23:0] out_b_o,
  output logic        mute_ind_o
);
  localparam int NCH = 2;

  logic [TO_LOG2-1:0] fcnt_q;
  logic               tick;
  logic [SMP_W-1:0]   smp  [NCH];
  logic [SMP_W-1:0]   outs [NCH];
  logic [CODE_W-1:0]  code [NCH];
  logic               mute [NCH];
  logic [NCH-1:0]     am, rmute;
  logic               ind_q;

  // free-running frame count; each wrap is a timeout tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      fcnt_q <= '0;
    else if (frame_i) fcnt_q <= fcnt_q + 1'b1;
  end
  assign tick = frame_i && (fcnt_q == '0);

  assign smp[0]  = smp_a_i;
  assign smp[1]  = smp_b_i;
  assign code[0] = atten_a_i;
  assign code[1] = link_i ? atten_a_i : atten_b_i;
  assign mute[0] = mute_a_i;
  assign mute[1] = link_i ? mute_a_i : mute_b_i;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    vol_chan #(.SIL_RUN(SIL_RUN)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .frame_i    (frame_i),
      .tick_i     (tick),
      .smp_i      (smp[c]),
      .code_i     (code[c]),
      .mute_i     (mute[c]),
      .mode_i     (tmode_i),
      .am_en_i    (am_en_i),
      .out_o      (outs[c]),
      .am_o       (am[c]),
      .req_mute_o (rmute[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ind_q <= 1'b0;
    else if (frame_i) ind_q <= (&rmute) || (&am_nxt_all());
  end

  function automatic logic [NCH-1:0] am_nxt_all();
    // indicator follows auto-mute state as it is registered this frame
    return {g_ch[1].u_chan.am_nxt, g_ch[0].u_chan.am_nxt};
  endfunction

  assign out_a_o    = outs[0];
  assign out_b_o    = outs[1];
  assign mute_ind_o = ind_q;

  a_r12_ind_mute: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && mute_a_i && (mute_b_i || link_i)) |=> mute_ind_o);

  a_r10_link_same: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && link_i && !am_en_i && smp_a_i == smp_b_i && $past(link_i) && $past(frame_i) == 1'b0
     && tmode_i == TM_NOW) |=> out_a_o == out_b_o);
endmodule

// File: tb/stereo_vol_ramp_bench.sv
module stereo_vol_ramp_bench;
  localparam time CLK_PERIOD = 10ns;

  typedef struct {
    bit          chk;
    logic [23:0] ea;
    logic [23:0] eb;
    logic        ei;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame = 1'b0;
  logic [23:0] sa_d = '0, sb_d = '0;
  logic [6:0]  att_a = '0, att_b = '0;
  logic        mu_a = 1'b0, mu_b = 1'b0, lnk = 1'b0, am_en = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [23:0] out_a, out_b;
  logic        ind;
  logic        fr_q = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  exp_t q[$];

  int lvl_m[2] = '{0, 0};
  bit prv_m[2] = '{0, 0};
  int cnt_m[2] = '{0, 0};

  always #(CLK_PERIOD / 2) clk = ~clk;

  stereo_vol_ramp u_stereo_vol_ramp (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .frame_i    (frame),
    .smp_a_i    (sa_d),
    .smp_b_i    (sb_d),
    .atten_a_i  (att_a),
    .atten_b_i  (att_b),
    .mute_a_i   (mu_a),
    .mute_b_i   (mu_b),
    .link_i     (lnk),
    .tmode_i    (mode),
    .am_en_i    (am_en),
    .out_a_o    (out_a),
    .out_b_o    (out_b),
    .mute_ind_o (ind)
  );

  // R2 gain formula, from the requirement text
  function automatic longint gain_of(int l);
    if (l >= 760) return 0;
    return longint'($rtoi(65536.0 * (10.0 ** (-real'(l % 48) / 160.0)) + 0.5)) >>> (l / 48);
  endfunction

  function automatic logic [23:0] scl(logic signed [23:0] x, longint g);
    longint p;
    p = longint'(x) * g;
    return 24'((p + 32768) >>> 16);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_frame(input logic signed [23:0] sa, input logic signed [23:0] sb,
                          input bit chk, input string req);
    exp_t x;
    logic signed [23:0] s[2];
    logic [23:0] e[2];
    bit rm[2];
    bit amv[2];
    s[0] = sa;
    s[1] = sb;
    for (int ch = 0; ch < 2; ch++) begin
      int code, t;
      bit m, zc, sil;
      code = (ch == 1 && !lnk) ? int'(att_b) : int'(att_a);
      m    = (ch == 1 && !lnk) ? mu_b : mu_a;
      rm[ch] = m || code >= 95;
      t  = rm[ch] ? 760 : code * 8;
      zc = (s[ch] == 0) || (s[ch][23] != prv_m[ch]);
      case (mode)
        2'b00: lvl_m[ch] = t;
        2'b01: if (zc) lvl_m[ch] = t;
        2'b10: lvl_m[ch] += (lvl_m[ch] < t) ? 1 : (lvl_m[ch] > t) ? -1 : 0;
        default: if (zc) lvl_m[ch] += (lvl_m[ch] < t) ? 1 : (lvl_m[ch] > t) ? -1 : 0;
      endcase
      prv_m[ch] = s[ch][23];
      sil = (s[ch] == 0) || (s[ch] == -1);
      amv[ch] = am_en && sil && cnt_m[ch] >= 8191;
      if (am_en && sil) begin
        if (cnt_m[ch] < 8192) cnt_m[ch]++;
      end else cnt_m[ch] = 0;
      e[ch] = amv[ch] ? 24'd0 : scl(s[ch], gain_of(lvl_m[ch]));
    end
    x.chk = chk;
    x.ea  = e[0];
    x.eb  = e[1];
    x.ei  = (rm[0] && rm[1]) || (amv[0] && amv[1]);
    x.req = req;
    q.push_back(x);
    @(negedge clk);
    sa_d  = sa;
    sb_d  = sb;
    frame = 1'b1;
    @(negedge clk);
    frame = 1'b0;
  endtask

  // monitor: results due at the edge that samples the strobe (R13)
  always @(posedge clk) fr_q <= frame;
  always @(negedge clk) begin
    if (fr_q && q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      if (x.chk) begin
        check(out_a == x.ea, x.req, "out_a", $signed(out_a), $signed(x.ea));
        check(out_b == x.eb, x.req, "out_b", $signed(out_b), $signed(x.eb));
        check(ind == x.ei, x.req, "mute_ind", int'(ind), int'(x.ei));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    logic [23:0] hold_a;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(out_a == 0 && out_b == 0, "R1", "outputs after reset", int'(out_a | out_b), 0);
    check(ind == 0, "R1", "indicator after reset", int'(ind), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R4 unity gain, immediate mode
    do_frame(24'sd1000, -24'sd1000, 1, "R4");
    do_frame(24'sh7FFFFF, 24'sh800000, 1, "R2");
    hold_a = out_a;
    repeat (3) @(negedge clk);
    check(out_a == hold_a, "R13", "hold between strobes", int'(out_a), int'(hold_a));

    // R2 fixed attenuations
    att_a = 7'd6; att_b = 7'd3;
    do_frame(24'sd1000, -24'sd1001, 1, "R2");
    do_frame(-24'sd777777, 24'sd123457, 1, "R2");
    att_a = 7'd40; att_b = 7'd94;
    do_frame(24'sd4000000, -24'sd4000000, 1, "R2");

    // R3 mute codes and mute bit, R12 indicator
    att_a = 7'd10; att_b = 7'd95;
    do_frame(24'sd50000, 24'sd50000, 1, "R3");
    att_b = 7'd127;
    do_frame(-24'sd50000, -24'sd50000, 1, "R3");
    mu_a = 1'b1;
    do_frame(24'sd60000, 24'sd60000, 1, "R12");
    check(ind == 1'b1, "R12", "indicator with both muted", int'(ind), 1);
    mu_a = 1'b0; att_a = 7'd0; att_b = 7'd0;
    do_frame(24'sd60000, 24'sd60000, 1, "R12");

    // R10 link: B controls ignored
    lnk = 1'b1; att_a = 7'd12; att_b = 7'd0; mu_b = 1'b1;
    do_frame(24'sd300000, 24'sd300000, 1, "R10");
    do_frame(24'sd123456, -24'sd654321, 1, "R10");
    lnk = 1'b0; mu_b = 1'b0; att_a = 7'd0;
    do_frame(24'sd2000, 24'sd2000, 1, "R4");

    // R5 zero-crossing mode, channels independent
    mode = 2'b01; att_a = 7'd10; att_b = 7'd10;
    do_frame(24'sd5000, 24'sd5000, 1, "R5");
    do_frame(24'sd5000, 24'sd5000, 1, "R5");
    do_frame(-24'sd5000, 24'sd5000, 1, "R5");
    do_frame(-24'sd4000, 24'sd0, 1, "R5");
    do_frame(-24'sd4000, 24'sd3000, 1, "R5");

    // R6 timeout without zero crossing
    mode = 2'b00; att_a = 7'd0; att_b = 7'd0;
    do_frame(24'sd1000, 24'sd1000, 1, "R6");
    mode = 2'b01; lnk = 1'b1; att_a = 7'd6;
    n = -1;
    for (int i = 0; i < 1100; i++) begin
      do_frame(24'sd1000, 24'sd1000, 0, "R6");
      if (out_a == 24'd500) begin
        n = i;
        break;
      end
    end
    check(n >= 512 && n <= 1024, "R6", "frames until forced change", n, 768);
    lvl_m[0] = 48; lvl_m[1] = 48;
    lnk = 1'b0; att_b = 7'd6;
    do_frame(24'sd1000, 24'sd1000, 1, "R6");

    // R7 ramp up and down
    mode = 2'b10; att_a = 7'd2; att_b = 7'd0;
    for (int i = 0; i < 50; i++) do_frame(24'(100000 * (i + 1)), 24'sd2500000, 1, "R7");
    att_a = 7'd0; att_b = 7'd1;
    for (int i = 0; i < 20; i++) do_frame(24'sd3000000, -24'sd3000000, 1, "R7");

    // R8 ramp stepping only on crossings
    mode = 2'b11; att_a = 7'd1; att_b = 7'd0;
    for (int i = 0; i < 3; i++) do_frame(24'sd300000, -24'sd300000, 1, "R8");
    for (int i = 0; i < 12; i++)
      do_frame((i % 2 == 0) ? -24'sd300000 : 24'sd300000, -24'sd300000, 1, "R8");

    // R9 mute fades in ramp mode
    mode = 2'b10; mu_a = 1'b1;
    for (int i = 0; i < 770; i++) do_frame(24'sd1048576, 24'sd1048576, 1, "R9");
    check(out_a == 0, "R9", "faded to silence", int'(out_a), 0);
    mode = 2'b00; mu_a = 1'b0; att_a = 7'd0; att_b = 7'd0;
    do_frame(24'sd7, 24'sd7, 1, "R4");

    // R11 auto-mute on silent runs, R12 indicator
    am_en = 1'b1;
    for (int i = 0; i < 8195; i++) do_frame(-24'sd1, 24'sd0, (i < 4 || i > 8185), "R11");
    check(ind == 1'b1, "R12", "indicator with both auto-muted", int'(ind), 1);
    check(out_a == 0, "R11", "silent run muted", $signed(out_a), 0);
    do_frame(24'sd5, -24'sd1, 1, "R11");
    check(out_a == 24'd5, "R11", "release on non-silent", $signed(out_a), 5);
    am_en = 1'b0;
    do_frame(-24'sd1, -24'sd1, 1, "R11");
    check(out_b == 24'hFFFFFF, "R11", "disabled passes silence", $signed(out_b), -1);

    repeat (4) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule